// File: doc/BRIEF.md
# Serial Status Readback Shift Register

This block is the serial front end of a multi-channel output driver. A single shift register, one bit wider than the channel count, handles two jobs. It carries control data in from a serial pin. It also carries per-channel fault status back out on the same path. Serial data is clocked in with a serial clock. On a latch pulse, the top bit of the register picks the destination: either the on-off word that gates the channels, or a control word handed to a neighbouring block.

When the destination is the on-off word, the block can also refill the low bits of the register with a status word. The status word comes from one of three fault vectors (open, short, leakage), chosen by a 2-bit detector-select code. Each code also has its own global flag, which turns the whole status word into all ones. The status is then clocked out of the serial output.

An interlock ignores repeated latch pulses until fresh data has been shifted in. After power-save mode ends, a blanking window marks status as untrustworthy, and any load made inside that window is remembered in a sticky flag. The serial clock, latch, serial data and power-save inputs are synchronised to the system clock before use.

Top module: `srb_readback`

## Requirements
- R1: After a synchronous active-high reset, the shift register, `onoff`, `ctl_word`, `sdo`, `status_invalid` and `status_stale` are all zero.
- R2: Each rising edge of `sclk` moves the register one place toward `sdo`. `sdi` enters at bit 0 and `sdo` always shows bit 16. After 17 edges, a word sent MSB first sits in the register, and it reads back MSB first on `sdo`.
- R3: An accepted latch with register bit 16 = 0 copies bits 15:0 into `onoff` and leaves `ctl_word` alone. With bit 16 = 1, it copies bits 15:0 into `ctl_word`, leaves `onoff` alone, and loads no status.
- R4: A status load happens only on an accepted latch with bit 16 = 0 and `det_sel` ≠ 00. It writes bits 15:0 only, so bit 16 keeps its value. With `det_sel` = 00, the register is left unchanged.
- R5: The `det_sel` code 01 loads `open_flt`, 10 loads `short_flt` and 11 loads `leak_flt`. Status bit n reports channel n.
- R6: With code 01, `ot_flag` = 1 forces all 16 status bits to 1. With code 10, `ptw_flag` does the same, and with code 11, `rshort_flag` does. A flag has no effect under the other codes.
- R7: A latch is accepted only if at least one `sclk` edge has occurred since the last accepted latch (or since reset). An unaccepted latch changes neither the register nor either latched word.
- R8: Re-sending the on-off data already held, followed by a latch, leaves `onoff` unchanged but performs a fresh status load.
- R9: If a latch edge and an `sclk` edge are seen in the same cycle, an accepted latch takes priority and that shift is dropped. An unaccepted latch lets the shift go ahead.
- R10: `status_invalid` is 1 while power save is active. It stays 1 for `BLANK_CYCLES` cycles after the synchronised power-save input goes low.
- R11: A status load made while `status_invalid` = 1 sets `status_stale`. A later status load made while `status_invalid` = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Serial shift clock, sampled |
| lat | input | 1 | Latch strobe, sampled |
| det_sel | input | 2 | Detector select code |
| open_flt | input | CH | Per-channel open-detect results |
| short_flt | input | CH | Per-channel short-detect results |
| leak_flt | input | CH | Per-channel leakage results |
| ot_flag | input | 1 | Over-temperature shutdown flag |
| ptw_flag | input | 1 | Pre-thermal warning flag |
| rshort_flag | input | 1 | Reference-pin short flag |
| psave | input | 1 | Power-save active |
| sdo | output | 1 | Serial data out (register bit 16) |
| onoff | output | CH | Latched on-off word |
| ctl_word | output | CH | Latched control word |
| status_invalid | output | 1 | Status not trustworthy now |
| status_stale | output | 1 | A load happened during the invalid window |

## Verification
A serial clock edge and a latch edge can reach the core in the same system cycle. In that case, the block must decide whether the shift or the latch owns that cycle. The bench provokes this by raising `sclk` and `lat` together, in two situations. First, right after fresh data, where the latch must win, drop the shift and load status. Second, right after an accepted latch, where the latch must be ignored and the shift must land. Each case is judged by reading all 17 bits back serially and by checking `onoff`.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    DET_NONE  = 2'b00,
    DET_OPEN  = 2'b01,
    DET_SHORT = 2'b10,
    DET_LEAK  = 2'b11
  } det_sel_e;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srb_rise.sv
module srb_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/srb_status_sel.sv
module srb_status_sel
  import srb_pkg::*;
#(
  parameter int CH = 16
) (
  input  logic [1:0]    sel,
  input  logic [CH-1:0] open_flt,
  input  logic [CH-1:0] short_flt,
  input  logic [CH-1:0] leak_flt,
  input  logic          ot_flag,
  input  logic          ptw_flag,
  input  logic          rshort_flag,
  output logic [CH-1:0] word,
  output logic          has_word
);
  always_comb begin
    word     = '0;
    has_word = 1'b1;
    case (det_sel_e'(sel))
      DET_OPEN:  word = ot_flag     ? '1 : open_flt;
      DET_SHORT: word = ptw_flag    ? '1 : short_flt;
      DET_LEAK:  word = rshort_flag ? '1 : leak_flt;
      default:   has_word = 1'b0;
    endcase
  end
endmodule

// File: rtl/srb_blank_timer.sv
module srb_blank_timer #(
  parameter int BLANK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic psave,
  output logic invalid
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (psave)       cnt <= CW'(BLANK_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign invalid = (cnt != '0);
endmodule

// File: rtl/srb_shifter.sv
module srb_shifter #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic          load_en,
  input  logic [CH-1:0] load_word,
  output logic [CH:0]   q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_en)  q <= {q[CH], load_word};
    else if (shift_en) q <= {q[CH-1:0], sdi};
  end
endmodule

// File: rtl/srb_readback.sv
module srb_readback #(
  parameter int CH           = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sdi,
  input  logic          sclk,
  input  logic          lat,
  input  logic [1:0]    det_sel,
  input  logic [CH-1:0] open_flt,
  input  logic [CH-1:0] short_flt,
  input  logic [CH-1:0] leak_flt,
  input  logic          ot_flag,
  input  logic          ptw_flag,
  input  logic          rshort_flag,
  input  logic          psave,
  output logic          sdo,
  output logic [CH-1:0] onoff,
  output logic [CH-1:0] ctl_word,
  output logic          status_invalid,
  output logic          status_stale
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] lvl;
  logic [1:0]       edges;
  logic             sclk_rise, lat_rise, psave_s, sdi_s;
  logic [CH:0]      sreg;
  logic             msb, fresh, lat_accept, load_en, shift_en;
  logic [CH-1:0]    stat_word;
  logic             has_word;

  srb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({psave, sdi, lat, sclk}),
    .q   (lvl)
  );

  srb_rise #(.W(2)) u_rise (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl[1:0]),
    .rise (edges)
  );

  assign sclk_rise = edges[0];
  assign lat_rise  = edges[1];
  assign sdi_s     = lvl[2];
  assign psave_s   = lvl[3];

  srb_status_sel #(.CH(CH)) u_sel (
    .sel         (det_sel),
    .open_flt    (open_flt),
    .short_flt   (short_flt),
    .leak_flt    (leak_flt),
    .ot_flag     (ot_flag),
    .ptw_flag    (ptw_flag),
    .rshort_flag (rshort_flag),
    .word        (stat_word),
    .has_word    (has_word)
  );

  srb_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .psave   (psave_s),
    .invalid (status_invalid)
  );

  assign msb        = sreg[CH];
  assign lat_accept = lat_rise & fresh;
  assign load_en    = lat_accept & ~msb & has_word;
  assign shift_en   = sclk_rise & ~lat_accept;

  srb_shifter #(.CH(CH)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .sdi       (sdi_s),
    .load_en   (load_en),
    .load_word (stat_word),
    .q         (sreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      onoff        <= '0;
      ctl_word     <= '0;
      fresh        <= 1'b0;
      status_stale <= 1'b0;
    end else begin
      if (lat_accept && !msb) onoff    <= sreg[CH-1:0];
      if (lat_accept &&  msb) ctl_word <= sreg[CH-1:0];
      if (lat_accept)         fresh    <= 1'b0;
      else if (sclk_rise)     fresh    <= 1'b1;
      if (load_en)            status_stale <= status_invalid;
    end
  end

  assign sdo = sreg[CH];
endmodule

// File: rtl/srb_readback_chk.sv
module srb_readback_chk #(
  parameter int CH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          psave_s,
  input logic          sclk_rise,
  input logic          lat_rise,
  input logic          fresh,
  input logic          msb,
  input logic          sdo,
  input logic [CH-1:0] onoff,
  input logic [CH-1:0] ctl_word,
  input logic          status_invalid,
  input logic          status_stale
);
  assert_sdo_moves_on_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(sclk_rise));

  assert_msb_high_keeps_onoff_R3: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && fresh && msb) |=> $stable(onoff));

  assert_ignored_latch_R7: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && !fresh) |=> ($stable(onoff) && $stable(ctl_word)));

  assert_psave_blanks_R10: assert property (@(posedge clk) disable iff (rst)
    psave_s |=> status_invalid);

  assert_blank_ends_quietly_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(status_invalid) |-> (!psave_s && $past(!psave_s)));

  assert_stale_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(status_stale) |-> $past(status_invalid && lat_rise));
endmodule

bind srb_readback srb_readback_chk #(.CH(CH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .psave_s        (psave_s),
  .sclk_rise      (sclk_rise),
  .lat_rise       (lat_rise),
  .fresh          (fresh),
  .msb            (msb),
  .sdo            (sdo),
  .onoff          (onoff),
  .ctl_word       (ctl_word),
  .status_invalid (status_invalid),
  .status_stale   (status_stale)
);

// File: tb/tb_srb_readback.sv
`timescale 1ns/1ps
module tb_srb_readback;
  localparam int CH    = 16;
  localparam int BLANK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 0, sclk = 0, lat = 0, psave = 0;
  logic [1:0] det_sel = 2'b00;
  logic [CH-1:0] open_flt = '0, short_flt = '0, leak_flt = '0;
  logic ot_flag = 0, ptw_flag = 0, rshort_flag = 0;
  logic sdo, status_invalid, status_stale;
  logic [CH-1:0] onoff, ctl_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  srb_readback #(.CH(CH), .SYNC_STAGES(2), .BLANK_CYCLES(BLANK)) dut (
    .clk(clk), .rst(rst), .sdi(sdi), .sclk(sclk), .lat(lat),
    .det_sel(det_sel), .open_flt(open_flt), .short_flt(short_flt),
    .leak_flt(leak_flt), .ot_flag(ot_flag), .ptw_flag(ptw_flag),
    .rshort_flag(rshort_flag), .psave(psave), .sdo(sdo), .onoff(onoff),
    .ctl_word(ctl_word), .status_invalid(status_invalid),
    .status_stale(status_stale)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [CH:0] got, input logic [CH:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic pulse_lat();
    lat = 1'b1; tick(4);
    lat = 1'b0; tick(4);
  endtask

  task automatic send17(input logic [CH:0] w);
    for (int i = CH; i >= 0; i--) begin
      sdi = w[i]; tick(2);
      pulse_sclk();
    end
    sdi = 1'b0;
  endtask

  task automatic read17(output logic [CH:0] v);
    sdi = 1'b0;
    for (int i = CH; i >= 0; i--) begin
      v[i] = sdo;
      pulse_sclk();
    end
  endtask

  task automatic load_and_read(input string tag, input logic [CH:0] w, input logic [1:0] sel,
                               input logic [CH:0] exp);
    logic [CH:0] v;
    det_sel = sel;
    send17(w);
    pulse_lat();
    read17(v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    check("R1 sdo",      {16'h0, sdo}, '0);
    check("R1 onoff",    {1'b0, onoff}, '0);
    check("R1 ctl_word", {1'b0, ctl_word}, '0);
    check("R1 flags",    {15'h0, status_invalid, status_stale}, '0);
  endtask

  task automatic t_shift_and_plain_latch();
    load_and_read("R2/R4 sel00 register untouched", {1'b0, 16'hA5C3}, 2'b00, {1'b0, 16'hA5C3});
    check("R3 onoff from low bits", {1'b0, onoff}, {1'b0, 16'hA5C3});
  endtask

  task automatic t_selectors();
    open_flt = 16'h1234; short_flt = 16'h0F0F; leak_flt = 16'h8421;
    ptw_flag = 1'b1; rshort_flag = 1'b1;
    load_and_read("R5/R6 open vector, other flags no effect", {1'b0, 16'h0001}, 2'b01, {1'b0, 16'h1234});
    ot_flag = 1'b1;
    load_and_read("R6 ot forces ones", {1'b0, 16'h0002}, 2'b01, {1'b0, 16'hFFFF});
    ot_flag = 1'b0; ptw_flag = 1'b0;
    load_and_read("R5 short vector", {1'b0, 16'h0003}, 2'b10, {1'b0, 16'h0F0F});
    ptw_flag = 1'b1;
    load_and_read("R6 ptw forces ones", {1'b0, 16'h0004}, 2'b10, {1'b0, 16'hFFFF});
    ptw_flag = 1'b0; rshort_flag = 1'b0;
    load_and_read("R5 leak vector", {1'b0, 16'h0005}, 2'b11, {1'b0, 16'h8421});
    rshort_flag = 1'b1;
    load_and_read("R6 rshort forces ones", {1'b0, 16'h0006}, 2'b11, {1'b0, 16'hFFFF});
    rshort_flag = 1'b0;
  endtask

  task automatic t_interlock_and_rewrite();
    logic [CH:0] v;
    det_sel = 2'b01; open_flt = 16'h00AA;
    send17({1'b0, 16'h3C3C});
    pulse_lat();
    open_flt = 16'h5500;
    pulse_lat();
    read17(v);
    check("R7 ignored latch keeps status", v, {1'b0, 16'h00AA});
    check("R7 onoff held", {1'b0, onoff}, {1'b0, 16'h3C3C});
    send17({1'b0, 16'h3C3C});
    pulse_lat();
    check("R8 onoff unchanged", {1'b0, onoff}, {1'b0, 16'h3C3C});
    read17(v);
    check("R8 fresh status", v, {1'b0, 16'h5500});
  endtask

  task automatic t_msb_high();
    logic [CH:0] v;
    det_sel = 2'b01; open_flt = 16'hFFFF;
    send17({1'b1, 16'hBEEF});
    pulse_lat();
    check("R3 ctl_word captured", {1'b0, ctl_word}, {1'b0, 16'hBEEF});
    check("R3 onoff kept", {1'b0, onoff}, {1'b0, 16'h3C3C});
    read17(v);
    check("R4 no load when msb set", v, {1'b1, 16'hBEEF});
  endtask

  task automatic t_collision();
    logic [CH:0] v;
    det_sel = 2'b01; open_flt = 16'h7E57;
    send17({1'b0, 16'h1111});
    sdi = 1'b0; tick(2);
    lat = 1'b1; sclk = 1'b1; tick(4);
    lat = 1'b0; sclk = 1'b0; tick(4);
    check("R9 accepted latch wins onoff", {1'b0, onoff}, {1'b0, 16'h1111});
    read17(v);
    check("R9 shift dropped, status loaded", v, {1'b0, 16'h7E57});
    open_flt = 16'h8001;
    send17({1'b0, 16'h2222});
    pulse_lat();
    sdi = 1'b1; tick(2);
    lat = 1'b1; sclk = 1'b1; tick(4);
    lat = 1'b0; sclk = 1'b0; tick(4);
    check("R9 ignored latch keeps onoff", {1'b0, onoff}, {1'b0, 16'h2222});
    read17(v);
    check("R9 shift lands", v, {16'h8001, 1'b1});
  endtask

  task automatic t_power_save();
    det_sel = 2'b01; open_flt = 16'h0C0C;
    psave = 1'b1; tick(6);
    check("R10 invalid in psave", {16'h0, status_invalid}, 17'h1);
    send17({1'b0, 16'h0F00});
    pulse_lat();
    check("R11 stale set", {16'h0, status_stale}, 17'h1);
    psave = 1'b0;
    tick(BLANK + 1);
    check("R10 still blanked", {16'h0, status_invalid}, 17'h1);
    tick(2);
    check("R10 blank over", {16'h0, status_invalid}, 17'h0);
    send17({1'b0, 16'h0F00});
    pulse_lat();
    check("R11 stale cleared by valid load", {16'h0, status_stale}, 17'h0);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_shift_and_plain_latch();
    t_selectors();
    t_interlock_and_rewrite();
    t_msb_high();
    t_collision();
    t_power_save();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule